// File: doc/BRIEF.md
# Segmented PWM Generator with Balanced Remainder

This block turns a duty word into a single-bit pulse train whose average equals the duty word divided by the frame length of 2^FRAME_BITS clocks. It does not make one long pulse per frame. Instead it cuts the frame into SLICES equal slices and puts one pulse at the start of every slice. The ripple a downstream low-pass filter must remove therefore sits at SLICES times the frame rate, and the full frame resolution is kept.

When the duty word is not a multiple of SLICES, the leftover clocks are given one at a time to chosen slices. A slice is chosen when the bit-reversed form of its index is below the leftover count, so the longer pulses end up spread evenly across the frame rather than grouped together.

The output is fully deterministic. A duty word is loaded by strobe into a holding register and copied into the active setting only at a frame boundary. A one-clock marker shows where each frame begins.

Top module: `seg_pwm`

## Requirements
- R1: While `rst` is high and in the first clock after it, `pwm_o` and `frame_start_o` are 0. The active duty after reset is 0, so the first frame is low throughout.
- R2: `frame_start_o` is high for exactly one clock in every 2^FRAME_BITS clocks. That clock is the first clock of a frame as seen on `pwm_o`.
- R3: A frame is made of SLICES slices, each 2^FRAME_BITS/SLICES clocks long and taken in time order j = 0 .. SLICES-1. In slice j, `pwm_o` is high from offset 0 for w_j consecutive clocks and low for the rest of the slice.
- R4: w_j = floor(D/SLICES) + e_j, where e_j = 1 if bitreverse(j) < (D mod SLICES), with j reversed over log2(SLICES) bits, and e_j = 0 otherwise. For SLICES = 4, a remainder of 1 extends slice 0, a remainder of 2 extends slices 0 and 2, and a remainder of 3 extends slices 0, 1 and 2.
- R5: A duty word loaded during a frame has no effect on that frame. It governs the whole of the next frame.
- R6: With D = 0, `pwm_o` stays low for the whole frame.
- R7: Any D at or above 2^FRAME_BITS-1 is treated as 2^FRAME_BITS-1. With that setting the output is high on every clock of the frame except the last one.
- R8: With SLICES = 8 the same rule as R4 applies, with a 3-bit reversal.
- R9: If several loads arrive within one frame, the last one before the boundary is the one applied.
- R10: While D is unchanged, consecutive frames are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that captures `duty_i` into the holding register |
| duty_i | input | FRAME_BITS+1 | Requested high clocks per frame; values above full scale are saturated |
| pwm_o | output | 1 | Registered PWM output |
| frame_start_o | output | 1 | Registered one-clock marker of a frame's first clock |

## Verification
`pwm_o` and `frame_start_o` are both registered one clock after the frame counter, so they stay aligned with each other. The bench therefore anchors every measurement on the clock in which `frame_start_o` is seen high at a falling edge. A loaded word first appears in the frame whose start marker follows the load. To make sure a whole frame is measured under the new setting, the load task leaves the frame-start clock before measuring begins. Each measurement then samples all 2^FRAME_BITS falling edges of one frame and compares every clock against the slice shape predicted from R3 and R4.

// File: rtl/seg_pwm_pkg.sv
package seg_pwm_pkg;

  // Number of bits needed to index v items (v a power of two, >= 2).
  function automatic int seg_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if ((1 << i) < v) r = i + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/seg_pwm_frame_ctr.sv
module seg_pwm_frame_ctr #(
  parameter int FRAME_BITS = 20,
  parameter int SLICE_BITS = 2,
  localparam int OFFS_BITS = FRAME_BITS - SLICE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  first_o,
  output logic                  last_o,
  output logic [SLICE_BITS-1:0] slice_o,
  output logic [OFFS_BITS-1:0]  offs_o
);

  logic [FRAME_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = &cnt_q;
  assign slice_o = cnt_q[FRAME_BITS-1 -: SLICE_BITS];
  assign offs_o  = cnt_q[OFFS_BITS-1:0];

endmodule

// File: rtl/seg_pwm_duty_latch.sv
module seg_pwm_duty_latch #(
  parameter int FRAME_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [FRAME_BITS:0]   duty_i,
  input  logic                  boundary_i,
  output logic [FRAME_BITS-1:0] active_o
);

  localparam logic [FRAME_BITS-1:0] FULL = '1;

  logic [FRAME_BITS-1:0] sat_w;
  logic [FRAME_BITS-1:0] pending_q;

  // Saturate the request to full scale.
  assign sat_w = duty_i[FRAME_BITS] ? FULL : duty_i[FRAME_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      active_o  <= '0;
    end else begin
      if (load_i) pending_q <= sat_w;
      // The setting changes only as the frame wraps; a load in the same
      // clock takes the direct path so it is not lost.
      if (boundary_i) active_o <= load_i ? sat_w : pending_q;
    end
  end

  // R5: the active setting holds still everywhere except at the wrap.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> $stable(active_o));

  // R7: an oversize request lands in the holding register as full scale.
  assert_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && duty_i[FRAME_BITS]) |=> (pending_q == FULL));

endmodule

// File: rtl/seg_pwm_shaper.sv
module seg_pwm_shaper #(
  parameter int FRAME_BITS = 20,
  parameter int SLICE_BITS = 2,
  localparam int OFFS_BITS = FRAME_BITS - SLICE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAME_BITS-1:0] active_i,
  input  logic [SLICE_BITS-1:0] slice_i,
  input  logic [OFFS_BITS-1:0]  offs_i,
  input  logic                  first_i,
  output logic                  pwm_o,
  output logic                  frame_start_o
);

  localparam logic [FRAME_BITS-1:0] FULL = '1;

  logic [SLICE_BITS-1:0] rank_w;
  logic [OFFS_BITS-1:0]  base_w;
  logic [SLICE_BITS-1:0] rem_w;
  logic                  extra_w;
  logic [OFFS_BITS:0]    width_w;
  logic                  high_w;

  // Bit-reversed slice index gives the order in which slices take
  // the leftover clocks.
  for (genvar g = 0; g < SLICE_BITS; g++) begin : g_rev
    assign rank_w[g] = slice_i[SLICE_BITS-1-g];
  end

  assign base_w  = active_i[FRAME_BITS-1:SLICE_BITS];
  assign rem_w   = active_i[SLICE_BITS-1:0];
  assign extra_w = (rank_w < rem_w);
  assign width_w = {1'b0, base_w} + {{OFFS_BITS{1'b0}}, extra_w};
  assign high_w  = ({1'b0, offs_i} < width_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o         <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pwm_o         <= high_w;
      frame_start_o <= first_i;
    end
  end

  // R6: a zero setting never drives the output high.
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (active_i == '0) |=> !pwm_o);

  // R7: full scale is high on every clock except the frame's last.
  assert_full_R7: assert property (@(posedge clk) disable iff (rst)
    ((active_i == FULL) && !(&{slice_i, offs_i})) |=> pwm_o);

  // R3: with a nonzero base width each slice opens with a high clock.
  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    ((offs_i == '0) && (base_w != '0)) |=> pwm_o);

endmodule

// File: rtl/seg_pwm.sv
module seg_pwm
  import seg_pwm_pkg::*;
#(
  parameter int FRAME_BITS = 20,
  parameter int SLICES     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [FRAME_BITS:0] duty_i,
  output logic                pwm_o,
  output logic                frame_start_o
);

  localparam int SLICE_BITS = seg_log2(SLICES);
  localparam int OFFS_BITS  = FRAME_BITS - SLICE_BITS;

  logic                  first_w;
  logic                  last_w;
  logic [SLICE_BITS-1:0] slice_w;
  logic [OFFS_BITS-1:0]  offs_w;
  logic [FRAME_BITS-1:0] active_w;

  seg_pwm_frame_ctr #(
    .FRAME_BITS(FRAME_BITS),
    .SLICE_BITS(SLICE_BITS)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .first_o (first_w),
    .last_o  (last_w),
    .slice_o (slice_w),
    .offs_o  (offs_w)
  );

  seg_pwm_duty_latch #(
    .FRAME_BITS(FRAME_BITS)
  ) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .duty_i     (duty_i),
    .boundary_i (last_w),
    .active_o   (active_w)
  );

  seg_pwm_shaper #(
    .FRAME_BITS(FRAME_BITS),
    .SLICE_BITS(SLICE_BITS)
  ) u_shape (
    .clk           (clk),
    .rst           (rst),
    .active_i      (active_w),
    .slice_i       (slice_w),
    .offs_i        (offs_w),
    .first_i       (first_w),
    .pwm_o         (pwm_o),
    .frame_start_o (frame_start_o)
  );

  // R2: the frame marker follows the counter's first clock.
  assert_marker_R2: assert property (@(posedge clk) disable iff (rst)
    first_w |=> frame_start_o);

  // R2: the marker lasts exactly one clock.
  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);

endmodule

// File: tb/seg_pwm_bench.sv
module seg_pwm_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld4 = 1'b0;
  logic [8:0] d4  = '0;
  logic       ld8 = 1'b0;
  logic [9:0] d8  = '0;
  logic       pwm4, fs4, pwm8, fs8;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #4 clk = ~clk;  // 125 MHz

  seg_pwm #(.FRAME_BITS(8), .SLICES(4)) u_seg_pwm (
    .clk(clk), .rst(rst), .load_i(ld4), .duty_i(d4),
    .pwm_o(pwm4), .frame_start_o(fs4));

  seg_pwm #(.FRAME_BITS(9), .SLICES(8)) u_seg_pwm_k8 (
    .clk(clk), .rst(rst), .load_i(ld8), .duty_i(d8),
    .pwm_o(pwm8), .frame_start_o(fs8));

  // Vector table for the 4-slice unit: 256-clock frame, 64-clock slices.
  localparam int NV = 12;
  localparam int TV_D [NV] = '{0, 1, 2, 3, 4, 101, 102, 103, 128, 255, 300, 511};
  localparam int TV_W [NV][4] = '{
    '{0, 0, 0, 0}, '{1, 0, 0, 0}, '{1, 0, 1, 0}, '{1, 1, 1, 0},
    '{1, 1, 1, 1}, '{26, 25, 25, 25}, '{26, 25, 26, 25}, '{26, 26, 26, 25},
    '{32, 32, 32, 32}, '{64, 64, 64, 63}, '{64, 64, 64, 63}, '{64, 64, 64, 63}};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected slice width from R4/R7.
  function automatic int expw(input int sel, input int d, input int j);
    int l, n, full, ds, rv;
    l = sel ? 3 : 2;
    n = sel ? 9 : 8;
    full = (1 << n) - 1;
    ds = (d > full) ? full : d;
    rv = 0;
    for (int b = 0; b < l; b++)
      if (((j >> b) & 1) == 1) rv = rv | (1 << (l - 1 - b));
    return (ds >> l) + ((rv < (ds & ((1 << l) - 1))) ? 1 : 0);
  endfunction

  task automatic load4(input int d);
    @(negedge clk); ld4 = 1'b1; d4 = d[8:0];
    @(negedge clk); ld4 = 1'b0;
  endtask

  task automatic load8(input int d);
    @(negedge clk); ld8 = 1'b1; d8 = d[9:0];
    @(negedge clk); ld8 = 1'b0;
  endtask

  // Measure one frame, checking every clock's shape (R3) and marker (R2).
  task automatic measure(input int sel, input int d, input string req,
                         input bit mid, input int mid_val, output int w [8]);
    int fl, errs, fserr, first_bad;
    bit p, f, e;
    fl = sel ? 512 : 256;
    errs = 0; fserr = 0; first_bad = -1;
    for (int j = 0; j < 8; j++) w[j] = 0;
    while (!(sel ? fs8 : fs4)) @(negedge clk);
    for (int o = 0; o < fl; o++) begin
      p = sel ? pwm8 : pwm4;
      f = sel ? fs8 : fs4;
      e = ((o % 64) < expw(sel, d, o / 64));
      if (p) w[o / 64]++;
      if (p !== e) begin
        errs++;
        if (first_bad < 0) first_bad = o;
      end
      if (f !== (o == 0)) fserr++;
      if (mid) begin
        if (o == fl / 2) begin ld4 = 1'b1; d4 = mid_val[8:0]; end
        else ld4 = 1'b0;
      end
      @(negedge clk);
    end
    check(errs == 0, req, $sformatf("shape D=%0d mismatched clocks (first at %0d)", d, first_bad), errs, 0);
    check(fserr == 0, "R2", $sformatf("frame marker misplaced D=%0d", d), fserr, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int w [8];
    int wa [8];
    bit ok;
    int bad;

    // R1: reset state.
    repeat (5) @(negedge clk);
    check(pwm4 === 1'b0 && fs4 === 1'b0, "R1", "outputs during reset", pwm4, 0);
    check(pwm8 === 1'b0 && fs8 === 1'b0, "R1", "k8 outputs during reset", pwm8, 0);
    rst = 1'b0;
    measure(0, 0, "R1", 1'b0, 0, w);

    // R4/R6/R7: vector table walk.
    for (int i = 0; i < NV; i++) begin
      load4(TV_D[i]);
      measure(0, TV_D[i], (TV_D[i] == 0) ? "R6" : (TV_D[i] >= 255 ? "R7" : "R4"), 1'b0, 0, w);
      ok = 1'b1; bad = 0;
      for (int j = 0; j < 4; j++)
        if (w[j] != TV_W[i][j]) begin ok = 1'b0; bad = j; end
      check(ok, "R4", $sformatf("table width D=%0d slice %0d", TV_D[i], bad), w[bad], TV_W[i][bad]);
    end

    // R10: consecutive frames identical with a steady setting.
    load4(77);
    measure(0, 77, "R10", 1'b0, 0, wa);
    measure(0, 77, "R10", 1'b0, 0, w);
    ok = 1'b1;
    for (int j = 0; j < 4; j++) if (w[j] != wa[j]) ok = 1'b0;
    check(ok, "R10", "repeat frame slice0 width", w[0], wa[0]);

    // R5: a load in mid-frame leaves that frame alone, applies next.
    measure(0, 77, "R5", 1'b1, 150, w);
    measure(0, 150, "R5", 1'b0, 0, w);

    // R9: last of two loads in one frame wins.
    load4(7);
    load4(9);
    measure(0, 9, "R9", 1'b0, 0, w);
    check(w[0] == 3 && w[1] == 2 && w[2] == 2 && w[3] == 2, "R9", "slice0 width", w[0], 3);

    // R8: eight-slice unit, 512-clock frame.
    load8(163);
    measure(1, 163, "R8", 1'b0, 0, w);
    check(w[0] == 21 && w[1] == 20 && w[2] == 21 && w[3] == 20 &&
          w[4] == 21 && w[5] == 20 && w[6] == 20 && w[7] == 20,
          "R8", "k8 rem3 slice4 width", w[4], 21);
    load8(85);
    measure(1, 85, "R8", 1'b0, 0, w);
    check(w[1] == 11 && w[3] == 10 && w[6] == 11 && w[7] == 10,
          "R8", "k8 rem5 slice6 width", w[6], 11);
    load8(600);
    measure(1, 600, "R7", 1'b0, 0, w);
    check(w[7] == 63 && w[0] == 64, "R7", "k8 saturated last slice", w[7], 63);
    load8(0);
    measure(1, 0, "R6", 1'b0, 0, w);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule